// File: doc/BRIEF.md
# A20-Gated Bounded Memory Port

This block is a memory port for a 24-bit physical address space, fronting a byte-organised RAM that may hold fewer bytes than the address space can reach. Every request first goes through a software-controlled gate on address bit 20. While the gate is closed, that bit is cleared before the address is used. While it is open, the address passes through unchanged. The gated address is then compared against the installed RAM size. Reads that start at or above that size return all ones, and writes that start there are dropped.

A request carries a width code for byte, word or doubleword, a write flag, an address and write data. Reads answer on the following cycle with little-endian data, right-aligned. The gate is changed through a one-cycle control strobe. The installed size is a parameter. When it covers the whole address space, the range check is not built, and a multi-byte access at the top of memory wraps around to address zero.

Top module: `a20_mem_gate`

## Requirements
- R1: After reset the gate is open: an address with bit 20 set is used as given, not folded onto its low alias.
- R2: While the gate is closed, the effective address equals the request address with bit 20 forced to zero, so an access at A | 0x100000 reaches the byte at A.
- R3: While the gate is open, the effective address equals the request address on every bit.
- R4: A read whose effective start address is at or above the installed size returns 0x000000FF for size code 0 (byte), 0x0000FFFF for code 1 (word) and 0xFFFFFFFF for codes 2 and 3 (doubleword).
- R5: A write whose effective start address is at or above the installed size changes no stored byte.
- R6: When the installed size equals the whole address space, no access is out of range, and lane k of a multi-byte access reaches address (start + k) modulo the address space.
- R7: An in-range read returns byte start+k in bits 8k+7..8k for each lane k of the requested width, with the bits above the width zero. An in-range write stores byte k of the write data at start+k.
- R8: The range test uses only the start address. A lane of an in-range access that falls at or beyond the installed size reads as 0xFF and is not written.
- R9: A gate change made in the same cycle as a request does not apply to that request. It applies from the next request onward. ctl_a20=1 opens the gate and ctl_a20=0 closes it.
- R10: rsp_valid is high in the cycle after a read request and low after a write request or an idle cycle. rsp_rdata is zero when rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Strobe that loads the gate setting |
| ctl_a20 | input | 1 | New gate setting: 1 open, 0 closed |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Width code: 0 byte, 1 word, 2 or 3 doubleword |
| req_addr | input | ADDR_W | Physical start address |
| req_wdata | input | 32 | Write data, little-endian, right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench builds two instances. The first keeps the 24-bit address and gate bit 20 but has only 256 bytes of RAM. This makes every start address, every straddle at the top byte and every fold from bit 20 reachable in one sweep. The second uses a 12-bit address, gates bit 8 and fills the whole space with 4096 bytes. This covers the full-size variant, where the range check is absent and lanes wrap at the top, as well as a gate that aliases half of the installed RAM.

// File: rtl/a20_mem_pkg.sv
package a20_mem_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_ALT   = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic       rd;
        acc_size_e  size;
        logic       oob;
    } rsp_ctl_t;

    function automatic logic [LANES-1:0] lane_mask(input acc_size_e sz);
        case (sz)
            SZ_BYTE: lane_mask = 4'b0001;
            SZ_WORD: lane_mask = 4'b0011;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ones_for(input acc_size_e sz);
        logic [LANES-1:0] m;
        m = lane_mask(sz);
        for (int i = 0; i < LANES; i++)
            ones_for[8*i +: 8] = m[i] ? 8'hFF : 8'h00;
    endfunction

endpackage

// File: rtl/a20_gate.sv
module a20_gate #(
    parameter int ADDR_W  = 24,
    parameter int A20_BIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic              ctl_a20,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              a20_on,
    output logic [ADDR_W-1:0] addr_out
);

    always_ff @(posedge clk) begin
        if (rst)
            a20_on <= 1'b1;
        else if (ctl_we)
            a20_on <= ctl_a20;
    end

    generate
        if (A20_BIT < ADDR_W) begin : g_mask
            localparam logic [ADDR_W-1:0] CLR = ~(ADDR_W'(1) << A20_BIT);
            always_comb addr_out = a20_on ? addr_in : (addr_in & CLR);
        end else begin : g_pass
            always_comb addr_out = addr_in;
        end
    endgenerate

endmodule

// File: rtl/a20_bounds.sv
module a20_bounds
    import a20_mem_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int RAM_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              oob,
    output logic [LANES-1:0]  lane_ok
);

    localparam bit FULL  = (RAM_BYTES == (1 << ADDR_W));
    localparam int EXT_W = ADDR_W + 2;
    localparam logic [EXT_W-1:0] LIMIT = EXT_W'(RAM_BYTES);

    generate
        if (FULL) begin : g_full
            always_comb begin
                oob     = 1'b0;
                lane_ok = '1;
            end
        end else begin : g_part
            always_comb begin
                oob = (EXT_W'(addr) >= LIMIT);
                for (int i = 0; i < LANES; i++)
                    lane_ok[i] = ((EXT_W'(addr) + EXT_W'(i)) < LIMIT);
            end
        end
    endgenerate

endmodule

// File: rtl/a20_byte_ram.sv
module a20_byte_ram
    import a20_mem_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int RAM_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;

    logic [7:0]       mem [RAM_BYTES];
    logic [IDX_W-1:0] idx [LANES];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic [ADDR_W-1:0] la;
            la     = addr + ADDR_W'(i);
            idx[i] = la[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (lane_we[i])
                mem[idx[i]] <= wdata[8*i +: 8];
            if (rd_en)
                rdata[8*i +: 8] <= mem[idx[i]];
        end
    end

endmodule

// File: rtl/a20_mem_gate.sv
module a20_mem_gate
    import a20_mem_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int A20_BIT   = 20,
    parameter int RAM_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic              ctl_a20,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);

    acc_size_e         size_e;
    logic              a20_on;
    logic [ADDR_W-1:0] eff_addr;
    logic              oob;
    logic [LANES-1:0]  lane_ok;
    logic [LANES-1:0]  lane_use;
    logic [LANES-1:0]  lane_we;
    logic              rd_en;
    logic [DATA_W-1:0] ram_rd;

    rsp_ctl_t          rq;
    logic [LANES-1:0]  lane_ok_q;

    always_comb begin
        size_e   = acc_size_e'(req_size);
        lane_use = lane_mask(size_e);
        rd_en    = req_valid && !req_write;
        for (int i = 0; i < LANES; i++)
            lane_we[i] = req_valid && req_write && !oob && lane_ok[i] && lane_use[i];
    end

    a20_gate #(.ADDR_W(ADDR_W), .A20_BIT(A20_BIT)) gate_i (
        .clk      (clk),
        .rst      (rst),
        .ctl_we   (ctl_we),
        .ctl_a20  (ctl_a20),
        .addr_in  (req_addr),
        .a20_on   (a20_on),
        .addr_out (eff_addr)
    );

    a20_bounds #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES)) bounds_i (
        .addr    (eff_addr),
        .oob     (oob),
        .lane_ok (lane_ok)
    );

    a20_byte_ram #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES)) ram_i (
        .clk     (clk),
        .rd_en   (rd_en),
        .lane_we (lane_we),
        .addr    (eff_addr),
        .wdata   (req_wdata),
        .rdata   (ram_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rq        <= '{rd: 1'b0, size: SZ_BYTE, oob: 1'b0};
            lane_ok_q <= '0;
        end else begin
            rq.rd <= rd_en;
            if (rd_en) begin
                rq.size   <= size_e;
                rq.oob    <= oob;
                lane_ok_q <= lane_ok;
            end
        end
    end

    always_comb begin
        logic [LANES-1:0] m;
        m         = lane_mask(rq.size);
        rsp_valid = rq.rd;
        rsp_rdata = '0;
        if (rq.rd) begin
            if (rq.oob) begin
                rsp_rdata = ones_for(rq.size);
            end else begin
                for (int i = 0; i < LANES; i++)
                    if (m[i])
                        rsp_rdata[8*i +: 8] = lane_ok_q[i] ? ram_rd[8*i +: 8] : 8'hFF;
            end
        end
    end

endmodule

// File: rtl/a20_mem_checker.sv
module a20_mem_checker
    import a20_mem_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int A20_BIT   = 20,
    parameter int RAM_BYTES = 4096
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_we,
    input logic              ctl_a20,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic              a20_on,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              oob,
    input logic [LANES-1:0]  lane_we,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata
);

    localparam bit FULL = (RAM_BYTES == (1 << ADDR_W));

    assert_reset_open_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> a20_on);

    generate
        if (A20_BIT < ADDR_W) begin : g_bit
            assert_closed_clears_R2: assert property (@(posedge clk) disable iff (rst)
                !a20_on |-> (eff_addr[A20_BIT] == 1'b0));
        end
        if (FULL) begin : g_full
            assert_never_oob_R6: assert property (@(posedge clk) disable iff (rst)
                !oob);
        end
    endgenerate

    assert_open_passes_R3: assert property (@(posedge clk) disable iff (rst)
        a20_on |-> (eff_addr == req_addr));

    assert_oob_ones_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && oob) |=>
            (rsp_rdata == ones_for(acc_size_e'($past(req_size)))));

    assert_oob_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        oob |-> (lane_we == '0));

    assert_gate_next_R9: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (a20_on == $past(ctl_a20)));

    assert_rsp_read_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> (!rsp_valid && rsp_rdata == '0));

endmodule

bind a20_mem_gate a20_mem_checker #(
    .ADDR_W    (ADDR_W),
    .A20_BIT   (A20_BIT),
    .RAM_BYTES (RAM_BYTES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_a20   (ctl_a20),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .a20_on    (a20_on),
    .eff_addr  (eff_addr),
    .oob       (oob),
    .lane_we   (lane_we),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
);

// File: tb/a20_mem_gate_tb_top.sv
module a20_mem_gate_tb_top;

    localparam int S_BYTES = 256;
    localparam int F_BYTES = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic        s_ctl_we = 0, s_ctl_a20 = 0, s_req_valid = 0, s_req_write = 0;
    logic [1:0]  s_req_size = 0;
    logic [23:0] s_req_addr = 0;
    logic [31:0] s_wdata = 0;
    logic        s_rsp_valid;
    logic [31:0] s_rdata;

    logic        f_ctl_we = 0, f_ctl_a20 = 0, f_req_valid = 0, f_req_write = 0;
    logic [1:0]  f_req_size = 0;
    logic [11:0] f_req_addr = 0;
    logic [31:0] f_wdata = 0;
    logic        f_rsp_valid;
    logic [31:0] f_rdata;

    a20_mem_gate #(.ADDR_W(24), .A20_BIT(20), .RAM_BYTES(S_BYTES)) dut_i (
        .clk(clk), .rst(rst), .ctl_we(s_ctl_we), .ctl_a20(s_ctl_a20),
        .req_valid(s_req_valid), .req_write(s_req_write), .req_size(s_req_size),
        .req_addr(s_req_addr), .req_wdata(s_wdata),
        .rsp_valid(s_rsp_valid), .rsp_rdata(s_rdata)
    );

    a20_mem_gate #(.ADDR_W(12), .A20_BIT(8), .RAM_BYTES(F_BYTES)) dut_full_i (
        .clk(clk), .rst(rst), .ctl_we(f_ctl_we), .ctl_a20(f_ctl_a20),
        .req_valid(f_req_valid), .req_write(f_req_write), .req_size(f_req_size),
        .req_addr(f_req_addr), .req_wdata(f_wdata),
        .rsp_valid(f_rsp_valid), .rsp_rdata(f_rdata)
    );

    logic [7:0] mdl [S_BYTES];
    bit s_gate = 1;

    function automatic logic [7:0] pat_s(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] pat_f(input int a);
        return 8'((a * 13 + (a >> 8)) & 255);
    endfunction

    function automatic int lanes_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_small(input logic [23:0] addr, input logic [1:0] sz, input bit gate);
        int ea;
        logic [31:0] r;
        ea = gate ? int'(addr) : int'(addr & 24'hEFFFFF);
        r = '0;
        for (int i = 0; i < lanes_of(sz); i++)
            r[8*i +: 8] = (ea >= S_BYTES || ea + i >= S_BYTES) ? 8'hFF : mdl[ea + i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic s_req(input bit wr, input logic [23:0] addr, input logic [1:0] sz,
                         input logic [31:0] wd, input bit cwe, input bit ca,
                         output logic [31:0] rd, output logic rv);
        @(negedge clk);
        s_req_valid = 1; s_req_write = wr; s_req_addr = addr; s_req_size = sz;
        s_wdata = wd; s_ctl_we = cwe; s_ctl_a20 = ca;
        @(negedge clk);
        rd = s_rdata; rv = s_rsp_valid;
        s_req_valid = 0; s_ctl_we = 0;
    endtask

    task automatic s_write(input logic [23:0] addr, input logic [1:0] sz, input logic [31:0] wd);
        logic [31:0] rd;
        logic rv;
        int ea;
        s_req(1, addr, sz, wd, 0, 0, rd, rv);
        ea = s_gate ? int'(addr) : int'(addr & 24'hEFFFFF);
        if (ea < S_BYTES)
            for (int i = 0; i < lanes_of(sz); i++)
                if (ea + i < S_BYTES) mdl[ea + i] = wd[8*i +: 8];
    endtask

    task automatic s_set_gate(input bit g);
        @(negedge clk);
        s_ctl_we = 1; s_ctl_a20 = g;
        @(negedge clk);
        s_ctl_we = 0;
        s_gate = g;
    endtask

    task automatic f_req(input bit wr, input logic [11:0] addr, input logic [1:0] sz,
                         input logic [31:0] wd, input bit cwe, input bit ca,
                         output logic [31:0] rd);
        @(negedge clk);
        f_req_valid = 1; f_req_write = wr; f_req_addr = addr; f_req_size = sz;
        f_wdata = wd; f_ctl_we = cwe; f_ctl_a20 = ca;
        @(negedge clk);
        rd = f_rdata;
        f_req_valid = 0; f_ctl_we = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic rv;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R10 reset rsp_valid", {31'd0, s_rsp_valid}, 32'd0);
        check("R10 reset rsp_rdata", s_rdata, 32'd0);

        for (int a = 0; a < S_BYTES; a++) s_write(24'(a), 2'd0, {24'd0, pat_s(a)});

        // R10: a write gives no response
        s_req(1, 24'h10, 2'd0, 32'h5A, 0, 0, rd, rv);
        mdl[16] = 8'h5A;
        check("R10 write no rsp", {31'd0, rv}, 32'd0);

        // R1: gate open after reset, so bit 20 is kept and the access is out of range
        s_req(0, 24'h100005, 2'd0, 0, 0, 0, rd, rv);
        check("R1 open after reset", rd, 32'h000000FF);
        check("R10 read rsp_valid", {31'd0, rv}, 32'd1);

        // R3 and R7/R8: open gate, sweep every start and width
        for (int a = 0; a < S_BYTES; a++)
            for (int sz = 0; sz < 4; sz++) begin
                s_req(0, 24'(a), 2'(sz), 0, 0, 0, rd, rv);
                check("R7 R8 R3 open sweep", rd, exp_small(24'(a), 2'(sz), 1));
            end

        // R4: out of range starts at each width
        for (int sz = 0; sz < 4; sz++) begin
            s_req(0, 24'(S_BYTES), 2'(sz), 0, 0, 0, rd, rv);
            check("R4 oob at limit", rd, exp_small(24'(S_BYTES), 2'(sz), 1));
            s_req(0, 24'hFFFFFF, 2'(sz), 0, 0, 0, rd, rv);
            check("R4 oob at top", rd, (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFFFFFF);
        end

        // R5: write while open to a bit-20 address is out of range and dropped
        s_write(24'h100020, 2'd2, 32'hDEADBEEF);
        s_write(24'h000300, 2'd2, 32'hCAFEF00D);
        s_set_gate(0);
        s_req(0, 24'h000020, 2'd2, 0, 0, 0, rd, rv);
        check("R5 oob write dropped", rd,
              {pat_s(35), pat_s(34), pat_s(33), pat_s(32)});

        // R2: closed gate folds bit 20, full sweep
        for (int a = 0; a < S_BYTES; a++)
            for (int sz = 0; sz < 3; sz++) begin
                s_req(0, 24'h100000 | 24'(a), 2'(sz), 0, 0, 0, rd, rv);
                check("R2 closed sweep", rd, exp_small(24'h100000 | 24'(a), 2'(sz), 0));
            end
        s_req(0, 24'h300010, 2'd0, 0, 0, 0, rd, rv);
        check("R2 other high bits kept", rd, 32'h000000FF);

        // R8: straddling write at the top keeps only in-range lanes
        s_write(24'h1000FE, 2'd2, 32'h11223344);
        s_req(0, 24'h0000FC, 2'd2, 0, 0, 0, rd, rv);
        check("R8 straddle write", rd, {8'h33, 8'h44, pat_s(253), pat_s(252)});
        s_req(0, 24'h0000FF, 2'd1, 0, 0, 0, rd, rv);
        check("R8 straddle read", rd, 32'h0000FF33);

        // R9: change in the same cycle as a request applies afterwards
        s_req(0, 24'h100040, 2'd0, 0, 1, 1, rd, rv);
        check("R9 same-cycle uses old closed", rd, {24'd0, mdl[64]});
        s_gate = 1;
        s_req(0, 24'h100040, 2'd0, 0, 0, 0, rd, rv);
        check("R9 next request uses open", rd, 32'h000000FF);
        s_req(0, 24'h100041, 2'd0, 0, 1, 0, rd, rv);
        check("R9 same-cycle uses old open", rd, 32'h000000FF);
        s_gate = 0;
        s_req(0, 24'h100041, 2'd0, 0, 0, 0, rd, rv);
        check("R9 next request uses closed", rd, {24'd0, mdl[65]});

        // R6: full-size instance, every start wraps and nothing is out of range
        for (int a = 0; a < F_BYTES; a++) f_req(1, 12'(a), 2'd0, {24'd0, pat_f(a)}, 0, 0, rd);
        for (int a = 0; a < F_BYTES; a++) begin
            f_req(0, 12'(a), 2'd2, 0, 0, 0, rd);
            exp = '0;
            for (int i = 0; i < 4; i++) exp[8*i +: 8] = pat_f((a + i) % F_BYTES);
            check("R6 full wrap sweep", rd, exp);
        end
        f_req(1, 12'hFFE, 2'd2, 32'hA1B2C3D4, 0, 0, rd);
        f_req(0, 12'h000, 2'd1, 0, 0, 0, rd);
        check("R6 full wrap write", rd, 32'h0000A1B2);
        f_req(0, 12'h000, 2'd0, 0, 1, 0, rd);
        for (int a = 256; a < 512; a++) begin
            f_req(0, 12'(a), 2'd0, 0, 0, 0, rd);
            exp = (a - 256 < 2) ? ((a == 256) ? 32'hB2 : 32'hA1) : {24'd0, pat_f(a - 256)};
            check("R2 R6 full closed alias", rd, exp);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule